// File: doc/BRIEF.md
# Deficiency-Based Unsigned Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product by working with each operand's distance below the base 2^N instead of with the operand itself. Each distance (the deficiency) is the operand's two's complement. An inner N-bit multiplier forms the product of the two deficiencies. The low N bits of that product become the low half of the result. Its high N bits are folded as a carry into the high half, which is built from the sum of the two deficiencies.

The arithmetic for the high half depends on an operating mode. The mode is decoded from the two operand MSBs only: both set, both clear, or one of each. It is exported as a 2-bit indication for debug. A zero operand has a deficiency that wraps to zero, so the block detects that case explicitly. The output stage can be a register or a plain wire, chosen by a parameter. The inner multiplier can be a plain operator or an unrolled shift-and-add array.

Top module: `ydm_mult`

## Requirements
- R1: For every pair of N-bit unsigned operands, `prod_o` equals the exact product `a_i * b_i` in 2N bits (checked exhaustively for N = 4).
- R2: When either operand is 0, `prod_o` is 0, even though the other operand's deficiency is nonzero.
- R3: `mode_o` encodes the MSB pattern of the operands: 2'b01 when both MSBs are 1, 2'b10 when both are 0, 2'b11 when they differ; 2'b00 appears only after reset.
- R4: The low N bits of `prod_o` equal the low N bits of D1*D2, where D1 = (2^N − a_i) mod 2^N and D2 = (2^N − b_i) mod 2^N.
- R5: With N = 4, a_i = 4'b1001 and b_i = 4'b0100 give `prod_o` = 8'b0010_0100 and `mode_o` = 2'b11.
- R6: With the registered output selected, `prod_o` and `mode_o` show the result for the operands present at a rising clock edge after that edge, and reset clears both to 0.
- R7: Every pairing of the boundary operands 0, 1, 2^(N−1)−1, 2^(N−1) and 2^N−1 gives the exact product, for N = 16 and N = 32.
- R8: Random operand pairs give the exact product for N = 16 and N = 32.
- R9: The high-half arithmetic is carried in N+2 bits, so that none of the three modes overflows before the result is cut to N bits.

Ports

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| prod_o | output | 2N | Unsigned product |
| mode_o | output | 2 | Decoded operand-MSB mode (debug) |

## Verification
On every clock, the assertions compare the combinational product with the exact product and check the forced zero result and the mode decode. They also check that the mode-1 high-half intermediate never goes negative in its N+2-bit field. Only the bench's scenarios can show the one-cycle register latency, the reset value, and correct results across the exhaustive 4-bit sweep, the boundary grid and the random 16- and 32-bit pairs. These are checked against a behavioural product computed independently in the bench.

// File: rtl/ydm_pkg.sv
package ydm_pkg;
   typedef enum logic [1:0] {
      MODE_NONE = 2'b00,
      MODE_HIGH = 2'b01,
      MODE_LOW  = 2'b10,
      MODE_MIX  = 2'b11
   } ydm_mode_e;
endpackage

// File: rtl/ydm_defic.sv
module ydm_defic #(
   parameter int N = 16
) (
   input  logic [N-1:0] x_i,
   output logic [N-1:0] d_o,
   output logic         zero_o
);
   // distance to 2^N, wrapping to zero for a zero operand
   assign d_o    = (~x_i) + N'(1);
   assign zero_o = (x_i == '0);
endmodule

// File: rtl/ydm_inner_mul.sv
module ydm_inner_mul #(
   parameter int N     = 16,
   parameter int STYLE = 0
) (
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [2*N-1:0] p_o
);
   localparam int PW = 2 * N;

   generate
      if (STYLE == 0) begin : g_op
         assign p_o = PW'(a_i) * PW'(b_i);
      end else begin : g_array
         logic [PW-1:0] acc [N+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < N; i++) begin : g_row
            logic [PW-1:0] part;
            assign part     = b_i[i] ? (PW'(a_i) << i) : '0;
            assign acc[i+1] = acc[i] + part;
         end
         assign p_o = acc[N];
      end
   endgenerate
endmodule

// File: rtl/ydm_upper.sv
module ydm_upper
   import ydm_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0] d1_i,
   input  logic [N-1:0] d2_i,
   input  logic [N-1:0] carry_i,
   input  ydm_mode_e    mode_i,
   output logic [N-1:0] upper_o,
   output logic [N+1:0] adj_o
);
   localparam int W = N + 2;
   localparam logic [W-1:0] BASE = W'(1) << N;

   logic [W-1:0] sum;
   logic [W-1:0] adj;
   logic [W-1:0] up;

   assign sum = W'(d1_i) + W'(d2_i);

   always_comb begin
      if (mode_i == MODE_LOW) begin
         // both small: deficiency sum overshoots the base, take it as is
         adj = sum - BASE;
         up  = W'(carry_i) - adj;
      end else begin
         // at least one large: complement the sum against the base
         adj = BASE - sum;
         up  = adj + W'(carry_i);
      end
   end

   assign upper_o = up[N-1:0];
   assign adj_o   = adj;
endmodule

// File: rtl/ydm_mult.sv
module ydm_mult
   import ydm_pkg::*;
#(
   parameter int N         = 16,
   parameter int MUL_STYLE = 0,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [2*N-1:0] prod_o,
   output logic [1:0]     mode_o
);
   localparam int PW = 2 * N;

   generate
      if (N < 2) begin : g_chk_n
         $error("ydm_mult: N must be at least 2");
      end
      if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_chk_style
         $error("ydm_mult: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [N-1:0]  d1, d2;
   logic          a_zero, b_zero;
   logic [PW-1:0] dprod;
   logic [N-1:0]  upper;
   logic [N+1:0]  adj;
   ydm_mode_e     mode_c;
   logic [PW-1:0] prod_c;

   ydm_defic #(.N(N)) u_defic_a (.x_i(a_i), .d_o(d1), .zero_o(a_zero));
   ydm_defic #(.N(N)) u_defic_b (.x_i(b_i), .d_o(d2), .zero_o(b_zero));

   ydm_inner_mul #(.N(N), .STYLE(MUL_STYLE)) u_dmul (
      .a_i(d1), .b_i(d2), .p_o(dprod)
   );

   always_comb begin
      unique case ({a_i[N-1], b_i[N-1]})
         2'b11:   mode_c = MODE_HIGH;
         2'b00:   mode_c = MODE_LOW;
         default: mode_c = MODE_MIX;
      endcase
   end

   ydm_upper #(.N(N)) u_upper (
      .d1_i(d1), .d2_i(d2), .carry_i(dprod[PW-1:N]),
      .mode_i(mode_c), .upper_o(upper), .adj_o(adj)
   );

   assign prod_c = (a_zero || b_zero) ? '0 : {upper, dprod[N-1:0]};

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               prod_o <= '0;
               mode_o <= MODE_NONE;
            end else begin
               prod_o <= prod_c;
               mode_o <= mode_c;
            end
         end
      end else begin : g_comb
         assign prod_o = prod_c;
         assign mode_o = mode_c;
      end
   endgenerate

   // R1: assembled product matches the exact product
   p_exact_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_c == (PW'(a_i) * PW'(b_i)))
      else $error("p_exact_r1");

   // R2: a zero operand forces a zero product
   p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_zero || b_zero) |-> (prod_c == '0))
      else $error("p_zero_r2");

   // R3: both MSBs set decode to the high mode, and no live mode is zero
   p_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i[N-1] && b_i[N-1]) |-> (u_upper.mode_i == MODE_HIGH))
      else $error("p_mode_r3");

   p_mode_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      u_upper.mode_i != MODE_NONE)
      else $error("p_mode_live_r3");

   // R9: in the high mode the complemented sum stays non-negative
   p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_c == MODE_HIGH && !a_zero && !b_zero) |-> (adj[N+1] == 1'b0))
      else $error("p_no_overflow_r9");
endmodule

// File: tb/test_ydm_mult.sv
`timescale 1ns/1ps
module test_ydm_mult;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [3:0]  a4 = '0, b4 = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic [31:0] a32 = '0, b32 = '0;
   logic [7:0]  p4;
   logic [31:0] p16;
   logic [63:0] p32;
   logic [1:0]  m4, m16, m32;

   ydm_mult #(.N(4), .MUL_STYLE(1), .REG_OUT(1'b1)) i_ydm_mult (
      .clk_i(clk), .rst_ni(rst_n), .a_i(a4), .b_i(b4), .prod_o(p4), .mode_o(m4));
   ydm_mult #(.N(16), .MUL_STYLE(0), .REG_OUT(1'b1)) i_ydm_mult_w16 (
      .clk_i(clk), .rst_ni(rst_n), .a_i(a16), .b_i(b16), .prod_o(p16), .mode_o(m16));
   ydm_mult #(.N(32), .MUL_STYLE(1), .REG_OUT(1'b1)) i_ydm_mult_w32 (
      .clk_i(clk), .rst_ni(rst_n), .a_i(a32), .b_i(b32), .prod_o(p32), .mode_o(m32));

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit pend = 0;
   string ptag;
   logic [3:0]  ea4, eb4;
   logic [15:0] ea16, eb16;
   logic [31:0] ea32, eb32;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] mode_of(input bit ma, input bit mb);
      if (ma && mb) return 2'b01;
      if (!ma && !mb) return 2'b10;
      return 2'b11;
   endfunction

   task automatic verify();
      logic [7:0]  e4;
      logic [31:0] e16;
      logic [63:0] e32;
      logic [15:0] d1, d2;
      logic [31:0] dd;
      e4  = {4'b0, ea4} * {4'b0, eb4};
      e16 = {16'b0, ea16} * {16'b0, eb16};
      e32 = {32'b0, ea32} * {32'b0, eb32};
      chk(p4 == e4, (ea4 == 0 || eb4 == 0) ? "R2" : "R1", 64'(p4), 64'(e4));
      chk(m4 == mode_of(ea4[3], eb4[3]), "R3", 64'(m4), 64'(mode_of(ea4[3], eb4[3])));
      chk(p16 == e16, ptag, 64'(p16), 64'(e16));
      chk(p32 == e32, ptag, p32, e32);
      d1 = 16'h0 - ea16;
      d2 = 16'h0 - eb16;
      dd = {16'b0, d1} * {16'b0, d2};
      chk(p16[15:0] == dd[15:0], "R4", 64'(p16[15:0]), 64'(dd[15:0]));
   endtask

   task automatic step(input logic [3:0] x4, input logic [3:0] y4,
                       input logic [15:0] x16, input logic [15:0] y16,
                       input logic [31:0] x32, input logic [31:0] y32,
                       input string tag);
      @(negedge clk);
      if (pend) verify();
      a4 = x4; b4 = y4; a16 = x16; b16 = y16; a32 = x32; b32 = y32;
      ea4 = x4; eb4 = y4; ea16 = x16; eb16 = y16; ea32 = x32; eb32 = y32;
      ptag = tag;
      pend = 1;
   endtask

   task automatic flush();
      @(negedge clk);
      if (pend) verify();
      pend = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] bd16 [5];
      logic [31:0] bd32 [5];
      logic [3:0]  bd4  [5];
      bd16 = '{16'h0, 16'h1, 16'h7fff, 16'h8000, 16'hffff};
      bd32 = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff};
      bd4  = '{4'h0, 4'h1, 4'h7, 4'h8, 4'hf};

      // R6: reset state, with nonzero operands applied during reset
      a4 = 4'hf; b4 = 4'he; a16 = 16'h1234; b16 = 16'h9abc; a32 = 32'hdeadbeef; b32 = 32'h1;
      repeat (3) @(negedge clk);
      chk(p4 == 8'h0, "R6", 64'(p4), 64'h0);
      chk(p16 == 32'h0 && p32 == 64'h0, "R6", 64'(p16), 64'h0);
      chk(m4 == 2'b00 && m16 == 2'b00, "R6", 64'(m4), 64'h0);
      rst_n = 1'b1;

      // R6: result appears one edge after the operands
      @(negedge clk);
      a4 = 4'h3; b4 = 4'h5;
      @(negedge clk);
      chk(p4 == 8'd15, "R6", 64'(p4), 64'd15);

      // R5: worked example, mixed mode
      @(negedge clk);
      a4 = 4'b1001; b4 = 4'b0100;
      @(negedge clk);
      chk(p4 == 8'b0010_0100, "R5", 64'(p4), 64'h24);
      chk(m4 == 2'b11, "R5", 64'(m4), 64'h3);

      // R1: exhaustive 4-bit sweep, with R2/R3 covered inside verify
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++)
            step(4'(i), 4'(j), 16'(i * 4099), 16'(j * 257 + 3),
                 32'(i * 268435459), 32'(j * 16777259), "R1");

      // R7: boundary grid for the wide instances
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++)
            step(bd4[i], bd4[j], bd16[i], bd16[j], bd32[i], bd32[j], "R7");

      // R8/R9: random vectors across all modes
      for (int k = 0; k < 2000; k++)
         step(4'($urandom), 4'($urandom), 16'($urandom), 16'($urandom),
              $urandom, $urandom, "R8");
      flush();

      // R3: wide instances report the mode of the held operands
      @(negedge clk);
      a16 = 16'h8001; b16 = 16'hc000; a32 = 32'h1; b32 = 32'h2;
      @(negedge clk);
      chk(m16 == 2'b01, "R3", 64'(m16), 64'h1);
      chk(m32 == 2'b10, "R3", 64'(m32), 64'h2);

      finish_run();
   end
endmodule